// File: doc/BRIEF.md
# Hot-Plug Event Notification Controller

This block sits beside one downstream slot's hot-plug logic and decides how each slot event gets reported upstream. It samples five slot event status flags every cycle, together with their individual enables, a slot-wide interrupt enable, the message-signalled interrupt enable, the legacy interrupt disable, a low-power (D3) indication and a legacy general-purpose-event mode flag. From these it produces a one-cycle MSI request pulse, a one-cycle power-management wake (PME) request pulse and a level-sensitive legacy INTx assert.

The status flags are write-one-to-clear bits kept elsewhere; this block never changes them. Request pulses fire on the rising edge of the combined pending-and-enabled condition, so software must clear every pending enabled event before a fresh event can raise another request. All outputs are registered and follow the inputs by one clock.

Event bit order on `evt_sts` and `evt_en`: bit 0 attention button, bit 1 power fault, bit 2 retention latch sensor changed, bit 3 presence changed, bit 4 command completed.

Top module: `hp_notify_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `msi_req`, `pme_req` and `intx_assert` are all 0.
- R2: An interrupt (MSI or INTx) is raised only when some event has both its `evt_sts` bit and its `evt_en` bit set and `glb_int_en` is 1.
- R3: With an interrupt condition present and `msi_en` = 1, `msi_req` is high for exactly one cycle, one clock after the condition appears, and `intx_assert` stays 0.
- R4: With an interrupt condition present, `msi_en` = 0 and `intx_dis` = 0, `intx_assert` is 1 one clock later and stays 1 while the condition holds, dropping one clock after the condition ends.
- R5: With `intx_dis` = 1 and `msi_en` = 0, `intx_assert` stays 0 and no MSI is requested.
- R6: With `low_pwr` = 1 and `glb_int_en` = 0, an enabled pending event (other than command completed) gives a single `pme_req` pulse and no interrupt; with `low_pwr` = 0, `pme_req` never rises.
- R7: With `low_pwr` = 1 and `glb_int_en` = 1, an enabled pending event (other than command completed) gives both a `pme_req` pulse and an interrupt in the same cycle.
- R8: An event whose `evt_en` bit is 0 produces no MSI, INTx or PME, in either power state.
- R9: The command completed event (bit 4) never produces `pme_req`; it can only produce an interrupt.
- R10: While `gpe_mode` is 1, `msi_req`, `pme_req` and `intx_assert` are 0 one clock later, whatever the other inputs.
- R11: No further MSI or PME pulse is issued while any enabled event remains pending; after all are cleared, a new event produces a new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_sts | input | 5 | Slot event status flags (bit order above) |
| evt_en | input | 5 | Per-event notification enables |
| glb_int_en | input | 1 | Slot-wide hot-plug interrupt enable |
| msi_en | input | 1 | Selects MSI delivery for interrupts |
| intx_dis | input | 1 | Blocks legacy INTx delivery |
| low_pwr | input | 1 | Port or device in D3 |
| gpe_mode | input | 1 | Legacy general-purpose-event mode; silences standard delivery |
| msi_req | output | 1 | One-cycle MSI request |
| pme_req | output | 1 | One-cycle wake message request |
| intx_assert | output | 1 | Legacy interrupt level |

## Verification
The only internal state is the pair of remembered conditions behind the two pulse generators and the registered outputs. A stuck-high memory would show at the ports as a missing request for the next event after clearing, visible one clock after that event appears; a stuck-low memory would show as a repeated `msi_req` or `pme_req` in the cycle right after a legitimate pulse. A wrong gating term shows within one clock as an output toggling on an input pattern that should leave it quiet, so the bench drives each pattern and samples the cycle after.

// File: rtl/hp_notify_pkg.sv
package hp_notify_pkg;
  localparam int unsigned EVT_CNT    = 5;
  localparam int unsigned EVT_ATTN   = 0;
  localparam int unsigned EVT_PFAULT = 1;
  localparam int unsigned EVT_LATCH  = 2;
  localparam int unsigned EVT_PRES   = 3;
  localparam int unsigned EVT_CMDDONE = 4;

  typedef struct packed {
    logic irq;
    logic msi;
    logic intx;
    logic wake;
  } hp_route_t;
endpackage

// File: rtl/hp_evt_gate.sv
module hp_evt_gate #(
  parameter int unsigned NUM_EVT = hp_notify_pkg::EVT_CNT,
  parameter int unsigned NOWAKE_IDX = hp_notify_pkg::EVT_CMDDONE
) (
  input  logic [NUM_EVT-1:0] sts,
  input  logic [NUM_EVT-1:0] en,
  input  logic               glb_int_en,
  input  logic               msi_en,
  input  logic               intx_dis,
  input  logic               low_pwr,
  input  logic               gpe_mode,
  output hp_notify_pkg::hp_route_t route
);
  logic [NUM_EVT-1:0] armed;
  logic [NUM_EVT-1:0] wake_src;

  assign armed = sts & en;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_wake
    if (i == NOWAKE_IDX) begin : g_excl
      assign wake_src[i] = 1'b0;
    end else begin : g_incl
      assign wake_src[i] = armed[i];
    end
  end

  always_comb begin
    route.irq  = (|armed) && glb_int_en && !gpe_mode;
    route.msi  = route.irq && msi_en;
    route.intx = route.irq && !msi_en && !intx_dis;
    route.wake = (|wake_src) && low_pwr && !gpe_mode;
  end
endmodule

// File: rtl/hp_req_pulse.sv
module hp_req_pulse (
  input  logic clk,
  input  logic rst,
  input  logic cond,
  output logic req
);
  logic cond_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q <= 1'b0;
      req    <= 1'b0;
    end else begin
      cond_q <= cond;
      req    <= cond && !cond_q;
    end
  end

  p_one_cycle_r11: assert property (@(posedge clk) disable iff (rst)
    req |=> !req);
endmodule

// File: rtl/hp_notify_ctrl.sv
module hp_notify_ctrl #(
  parameter int unsigned NUM_EVT = hp_notify_pkg::EVT_CNT,
  parameter int unsigned NOWAKE_IDX = hp_notify_pkg::EVT_CMDDONE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_sts,
  input  logic [NUM_EVT-1:0] evt_en,
  input  logic               glb_int_en,
  input  logic               msi_en,
  input  logic               intx_dis,
  input  logic               low_pwr,
  input  logic               gpe_mode,
  output logic               msi_req,
  output logic               pme_req,
  output logic               intx_assert
);
  localparam logic [NUM_EVT-1:0] WAKE_MASK = ~(NUM_EVT'(1) << NOWAKE_IDX);

  hp_notify_pkg::hp_route_t route;

  hp_evt_gate #(.NUM_EVT(NUM_EVT), .NOWAKE_IDX(NOWAKE_IDX)) u_gate (
    .sts(evt_sts), .en(evt_en), .glb_int_en(glb_int_en), .msi_en(msi_en),
    .intx_dis(intx_dis), .low_pwr(low_pwr), .gpe_mode(gpe_mode), .route(route)
  );

  hp_req_pulse u_msi_pulse (.clk(clk), .rst(rst), .cond(route.msi), .req(msi_req));
  hp_req_pulse u_pme_pulse (.clk(clk), .rst(rst), .cond(route.wake), .req(pme_req));

  always_ff @(posedge clk) begin
    if (rst) intx_assert <= 1'b0;
    else     intx_assert <= route.intx;
  end

  p_msi_excl_intx_r3: assert property (@(posedge clk) disable iff (rst)
    !(msi_req && intx_assert));
  p_masked_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(evt_sts & evt_en) == '0) |-> (!msi_req && !pme_req && !intx_assert));
  p_cmddone_nowake_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(evt_sts & evt_en & WAKE_MASK) == '0) |-> !pme_req);
  p_gpe_silent_r10: assert property (@(posedge clk) disable iff (rst)
    $past(gpe_mode) |-> (!msi_req && !pme_req && !intx_assert));
  p_awake_nowake_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(low_pwr) |-> !pme_req);
  p_irq_gated_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(glb_int_en) |-> (!msi_req && !intx_assert));
endmodule

// File: tb/hp_notify_ctrl_tb.sv
module hp_notify_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] evt_sts = '0, evt_en = '0;
  logic glb_int_en = 0, msi_en = 0, intx_dis = 0, low_pwr = 0, gpe_mode = 0;
  logic msi_req, pme_req, intx_assert;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  hp_notify_ctrl u_dut (
    .clk(clk), .rst(rst), .evt_sts(evt_sts), .evt_en(evt_en),
    .glb_int_en(glb_int_en), .msi_en(msi_en), .intx_dis(intx_dis),
    .low_pwr(low_pwr), .gpe_mode(gpe_mode),
    .msi_req(msi_req), .pme_req(pme_req), .intx_assert(intx_assert)
  );

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic outs(string tag, logic m, logic p, logic i);
    chk({tag, " msi_req"}, msi_req, m);
    chk({tag, " pme_req"}, pme_req, p);
    chk({tag, " intx_assert"}, intx_assert, i);
  endtask

  task automatic drive(logic [4:0] s, logic [4:0] e, logic g, logic m,
                       logic d, logic lp, logic gp);
    @(negedge clk);
    evt_sts = s; evt_en = e; glb_int_en = g; msi_en = m;
    intx_dis = d; low_pwr = lp; gpe_mode = gp;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    drive('0, '0, 0, 0, 0, 0, 0); step(); step();
  endtask

  task automatic t_reset();
    step(); outs("R1 in reset", 0, 0, 0);
    @(negedge clk); rst = 0;
    evt_sts = 5'h1F; evt_en = 5'h1F; glb_int_en = 1; low_pwr = 1;
    outs("R1 after reset", 0, 0, 0);
    idle();
  endtask

  task automatic t_msi_once();
    drive(5'b01000, 5'h1F, 1, 1, 0, 0, 0); step();
    outs("R3 msi pulse", 1, 0, 0);
    step(); outs("R3 pulse ends", 0, 0, 0);
    drive(5'b01001, 5'h1F, 1, 1, 0, 0, 0); step(); step();
    chk("R11 no repeat while pending", msi_req, 0);
    drive('0, 5'h1F, 1, 1, 0, 0, 0); step();
    drive(5'b00100, 5'h1F, 1, 1, 0, 0, 0); step();
    chk("R11 new pulse after clear", msi_req, 1);
    idle();
  endtask

  task automatic t_gating();
    drive(5'b00010, 5'b11101, 1, 1, 0, 0, 0); step(); step();
    outs("R2 event enable off", 0, 0, 0);
    drive(5'b00010, 5'h1F, 0, 0, 0, 0, 0); step(); step();
    outs("R2 global enable off", 0, 0, 0);
    idle();
  endtask

  task automatic t_intx();
    drive(5'b00001, 5'h1F, 1, 0, 0, 0, 0); step();
    outs("R4 intx rises", 0, 0, 1);
    step(); step(); chk("R4 intx held", intx_assert, 1);
    drive('0, 5'h1F, 1, 0, 0, 0, 0); step();
    chk("R4 intx drops", intx_assert, 0);
    idle();
  endtask

  task automatic t_intx_dis();
    drive(5'b00001, 5'h1F, 1, 0, 1, 0, 0); step(); step();
    outs("R5 intx blocked", 0, 0, 0);
    idle();
  endtask

  task automatic t_d3_off();
    drive(5'b00001, 5'h1F, 0, 1, 0, 1, 0); step();
    outs("R6 wake only", 0, 1, 0);
    step(); chk("R6 wake single", pme_req, 0);
    idle();
    drive(5'b00001, 5'h1F, 1, 1, 0, 0, 0); step();
    chk("R6 no wake when awake", pme_req, 0);
    idle();
  endtask

  task automatic t_d3_on();
    drive(5'b00010, 5'h1F, 1, 1, 0, 1, 0); step();
    outs("R7 wake and msi", 1, 1, 0);
    idle();
    drive(5'b00010, 5'h1F, 1, 0, 0, 1, 0); step();
    outs("R7 wake and intx", 0, 1, 1);
    idle();
  endtask

  task automatic t_masked();
    drive(5'h1F, '0, 1, 1, 0, 1, 0); step(); step();
    outs("R8 masked in D3", 0, 0, 0);
    drive(5'h1F, '0, 1, 0, 0, 0, 0); step();
    outs("R8 masked awake", 0, 0, 0);
    idle();
  endtask

  task automatic t_cmddone();
    drive(5'b10000, 5'h1F, 0, 1, 0, 1, 0); step();
    outs("R9 no wake global off", 0, 0, 0);
    idle();
    drive(5'b10000, 5'h1F, 1, 1, 0, 1, 0); step();
    outs("R9 irq only", 1, 0, 0);
    idle();
  endtask

  task automatic t_gpe();
    drive(5'h1F, 5'h1F, 1, 1, 0, 1, 1); step(); step();
    outs("R10 gpe msi path", 0, 0, 0);
    drive(5'h1F, 5'h1F, 1, 0, 0, 1, 1); step();
    outs("R10 gpe intx path", 0, 0, 0);
    idle();
  endtask

  initial begin
    fork
      begin
        t_reset(); t_msi_once(); t_gating(); t_intx(); t_intx_dis();
        t_d3_off(); t_d3_on(); t_masked(); t_cmddone(); t_gpe();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule